// File: doc/BRIEF.md
# Time-Triggered CAN Reference Synchronizer

This block follows the reference message of a time-triggered CAN network. Whenever the bus signals a start of frame, it copies the free-running local time into a holding register. That held value becomes the node's reference mark only when the frame proves to be a valid reference frame. A frame counts when it is received into the reference receive mailbox (slave role) or sent from the reference transmit mailbox (master role). A frame that starts but never completes as a reference leaves the mark unchanged.

The block also keeps the basic-cycle count. In the slave role the count is loaded from the received reference frame, and a gap indication in that frame raises a sticky interrupt flag. In the potential-master role the count advances once each time the cycle time reaches the reference trigger time, and wraps at a limit chosen by a cycle-max field. The block also builds the first data byte of the outgoing reference frame, with the count in the low bits. Both roles share one timestamp path. The role is decoded from mailbox configuration inputs. The CAN bit engine, arbitration and mailbox storage sit outside this block.

Top module: `ttcan_ref_sync`

## Requirements
- R1: On every cycle where `sof_i` is 1, the holding register takes `local_time_i`. The held value becomes visible only through `ref_mark_o`, after a later accepted reference frame.
- R2: `slave_mode_o` is 1 exactly when all of the following hold: `mb30_tx_pend_i` is 0, `mb30_cfg_i` is not 3'b000, `cyc_max_i` is not 3'b111, and `mb31_cfg_i` is 3'b011.
- R3: `master_mode_o` is 1 exactly when all of the following hold: `mb30_tx_pend_i` is 1, `mb30_cfg_i` is 3'b000, `mb30_dlc_i` is greater than 0, `cyc_max_i` is not 3'b111, and `mb31_cfg_i` is 3'b011. The two role outputs are never 1 together.
- R4: In the slave role, a cycle with `rx_ref_valid_i` at 1 does two things at the next clock edge. It copies the held value (the one held before that edge) into `ref_mark_o`. It loads `cyc_cnt_o` with `rx_data0_i[5:0]`. Outside the slave role, `rx_ref_valid_i` has no effect.
- R5: An accepted received reference frame with `rx_data0_i[GAP_BIT]` at 1 (GAP_BIT defaults to 7) sets `gap_irq_o` at the next edge. The flag stays set until a cycle with `irq_clr_i` at 1 clears it at the next edge. If a set and a clear fall in the same cycle, the set wins.
- R6: In the master role, a cycle with `tx_ref_done_i` at 1 copies the held value into `ref_mark_o` at the next edge. Outside the master role, `tx_ref_done_i` has no effect.
- R7: In the master role, the first cycle in which `cycle_time_i` equals `mb30_trig_i` advances `cyc_cnt_o` by one at the next edge. Later consecutive matching cycles do not advance it again. If the count is already at or above the limit 2^(cyc_max_i+1)-1, it goes to 0 instead. That limit is capped at 63 for a 6-bit count.
- R8: `tx_data0_o` equals `tx_data0_i[7:6]` followed by `cyc_cnt_o[5:0]`, combinationally.
- R9: Reset clears `ref_mark_o`, `cyc_cnt_o`, `gap_irq_o` and the holding register.
- R10: A start of frame that is not followed by an accepted reference frame leaves `ref_mark_o` at its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof_i | input | 1 | Start-of-frame pulse from the bit engine |
| local_time_i | input | 16 | Free-running local time |
| cycle_time_i | input | 16 | Current cycle time |
| rx_ref_valid_i | input | 1 | Valid reference frame stored in mailbox 31 |
| rx_data0_i | input | 8 | Data byte 0 of the received reference frame |
| tx_ref_done_i | input | 1 | Reference frame sent from mailbox 30 |
| tx_data0_i | input | 8 | Data byte 0 as held in mailbox 30 |
| mb30_tx_pend_i | input | 1 | Transmit-pending bit of mailbox 30 |
| mb30_cfg_i | input | 3 | Configuration field of mailbox 30 |
| mb30_dlc_i | input | 4 | Data length of mailbox 30 |
| mb30_trig_i | input | 16 | Trigger time of mailbox 30 |
| mb31_cfg_i | input | 3 | Configuration field of mailbox 31 |
| cyc_max_i | input | 3 | Cycle-max field |
| irq_clr_i | input | 1 | Clears the gap flag |
| slave_mode_o | output | 1 | Time-slave role active |
| master_mode_o | output | 1 | Potential-master role active |
| ref_mark_o | output | 16 | Reference mark |
| cyc_cnt_o | output | 6 | Basic-cycle count |
| tx_data0_o | output | 8 | Byte 0 for the outgoing reference frame |
| gap_irq_o | output | 1 | Sticky gap interrupt flag |

## Verification
Several properties are checked on every cycle. The roles never overlap and always need mailbox 31 set to the reference-receive value. Each start of frame lands in the holding register. The mark stays stable unless a reference frame is accepted, and an accepted frame delivers the held value. The count does not move while the cycle time misses the trigger and nothing is received. The gap flag obeys its set and hold rules. Other behaviours need the bench's scenarios, which compare against an independent cycle model: the exact count sequence across the wrap for several cycle-max values, the single advance during a long trigger match, the received count load, a set and clear landing together, and stray pulses being ignored in the wrong role.

// File: rtl/ttcan_ref_pkg.sv
package ttcan_ref_pkg;
   typedef enum logic [1:0] {
      ROLE_NONE   = 2'd0,
      ROLE_SLAVE  = 2'd1,
      ROLE_MASTER = 2'd2
   } role_e;

   localparam logic [2:0] RX_REF_CFG  = 3'b011;
   localparam logic [2:0] TX_REF_CFG  = 3'b000;
   localparam logic [2:0] CMAX_BARRED = 3'b111;
endpackage

// File: rtl/ttcan_role_decode.sv
module ttcan_role_decode
   import ttcan_ref_pkg::*;
#(
   parameter int DLC_W = 4
) (
   input  logic             tx_pend_i,
   input  logic [2:0]       mb30_cfg_i,
   input  logic [DLC_W-1:0] mb30_dlc_i,
   input  logic [2:0]       mb31_cfg_i,
   input  logic [2:0]       cyc_max_i,
   output role_e            role_o
);
   logic common_ok;
   logic slave_ok;
   logic master_ok;

   assign common_ok = (mb31_cfg_i == RX_REF_CFG) && (cyc_max_i != CMAX_BARRED);
   assign slave_ok  = common_ok && !tx_pend_i && (mb30_cfg_i != TX_REF_CFG);
   assign master_ok = common_ok && tx_pend_i && (mb30_cfg_i == TX_REF_CFG)
                      && (mb30_dlc_i != '0);

   always_comb begin
      role_o = ROLE_NONE;
      if (slave_ok)       role_o = ROLE_SLAVE;
      else if (master_ok) role_o = ROLE_MASTER;
   end
endmodule

// File: rtl/ttcan_sof_stamp.sv
module ttcan_sof_stamp #(
   parameter int TIME_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sof_i,
   input  logic [TIME_W-1:0] local_time_i,
   input  logic              commit_i,
   output logic [TIME_W-1:0] hold_o,
   output logic [TIME_W-1:0] mark_o
);
   logic [TIME_W-1:0] hold_q;
   logic [TIME_W-1:0] mark_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= '0;
         mark_q <= '0;
      end else begin
         if (sof_i)    hold_q <= local_time_i;
         if (commit_i) mark_q <= hold_q;
      end
   end

   assign hold_o = hold_q;
   assign mark_o = mark_q;
endmodule

// File: rtl/ttcan_cycle_count.sv
module ttcan_cycle_count #(
   parameter int TIME_W = 16,
   parameter int CYC_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [CYC_W-1:0]  load_val_i,
   input  logic              adv_en_i,
   input  logic [TIME_W-1:0] cycle_time_i,
   input  logic [TIME_W-1:0] trig_i,
   input  logic [2:0]        cyc_max_i,
   output logic [CYC_W-1:0]  cnt_o
);
   logic [CYC_W-1:0] cnt_q;
   logic [CYC_W-1:0] limit;
   logic             match;
   logic             match_q;
   logic             advance;

   for (genvar i = 0; i < CYC_W; i++) begin : g_limit
      assign limit[i] = (cyc_max_i >= 3'(i));
   end

   assign match   = (cycle_time_i == trig_i);
   assign advance = adv_en_i && match && !match_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         match_q <= 1'b0;
      end else begin
         match_q <= match;
         if (load_i)
            cnt_q <= load_val_i;
         else if (advance)
            cnt_q <= (cnt_q >= limit) ? '0 : cnt_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/ttcan_gap_flag.sv
module ttcan_gap_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   logic flag_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     flag_q <= 1'b0;
      else if (set_i) flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
   end

   assign flag_o = flag_q;
endmodule

// File: rtl/ttcan_ref_sync.sv
module ttcan_ref_sync
   import ttcan_ref_pkg::*;
#(
   parameter int TIME_W  = 16,
   parameter int CYC_W   = 6,
   parameter int DLC_W   = 4,
   parameter int GAP_BIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sof_i,
   input  logic [TIME_W-1:0] local_time_i,
   input  logic [TIME_W-1:0] cycle_time_i,
   input  logic              rx_ref_valid_i,
   input  logic [7:0]        rx_data0_i,
   input  logic              tx_ref_done_i,
   input  logic [7:0]        tx_data0_i,
   input  logic              mb30_tx_pend_i,
   input  logic [2:0]        mb30_cfg_i,
   input  logic [DLC_W-1:0]  mb30_dlc_i,
   input  logic [TIME_W-1:0] mb30_trig_i,
   input  logic [2:0]        mb31_cfg_i,
   input  logic [2:0]        cyc_max_i,
   input  logic              irq_clr_i,
   output logic              slave_mode_o,
   output logic              master_mode_o,
   output logic [TIME_W-1:0] ref_mark_o,
   output logic [CYC_W-1:0]  cyc_cnt_o,
   output logic [7:0]        tx_data0_o,
   output logic              gap_irq_o
);
   initial begin
      assert (TIME_W >= 8 && TIME_W <= 32) else $error("TIME_W out of range");
      assert (CYC_W >= 1 && CYC_W <= 7) else $error("CYC_W must fit in data byte 0");
      assert (GAP_BIT >= 0 && GAP_BIT <= 7) else $error("GAP_BIT outside byte");
      assert (DLC_W >= 1) else $error("DLC_W too small");
   end

   role_e             role;
   logic              rx_take;
   logic              tx_take;
   logic [TIME_W-1:0] sof_stamp_w;

   ttcan_role_decode #(.DLC_W(DLC_W)) u_role (
      .tx_pend_i  (mb30_tx_pend_i),
      .mb30_cfg_i (mb30_cfg_i),
      .mb30_dlc_i (mb30_dlc_i),
      .mb31_cfg_i (mb31_cfg_i),
      .cyc_max_i  (cyc_max_i),
      .role_o     (role)
   );

   assign slave_mode_o  = (role == ROLE_SLAVE);
   assign master_mode_o = (role == ROLE_MASTER);
   assign rx_take       = slave_mode_o && rx_ref_valid_i;
   assign tx_take       = master_mode_o && tx_ref_done_i;

   ttcan_sof_stamp #(.TIME_W(TIME_W)) u_stamp (
      .clk          (clk),
      .rst_n        (rst_n),
      .sof_i        (sof_i),
      .local_time_i (local_time_i),
      .commit_i     (rx_take || tx_take),
      .hold_o       (sof_stamp_w),
      .mark_o       (ref_mark_o)
   );

   ttcan_cycle_count #(.TIME_W(TIME_W), .CYC_W(CYC_W)) u_cycle (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_i       (rx_take),
      .load_val_i   (rx_data0_i[CYC_W-1:0]),
      .adv_en_i     (master_mode_o),
      .cycle_time_i (cycle_time_i),
      .trig_i       (mb30_trig_i),
      .cyc_max_i    (cyc_max_i),
      .cnt_o        (cyc_cnt_o)
   );

   ttcan_gap_flag u_gap (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (rx_take && rx_data0_i[GAP_BIT]),
      .clr_i  (irq_clr_i),
      .flag_o (gap_irq_o)
   );

   if (CYC_W == 7) begin : g_byte_narrow
      assign tx_data0_o = {tx_data0_i[7], cyc_cnt_o};
   end else begin : g_byte_wide
      assign tx_data0_o = {tx_data0_i[7:CYC_W], cyc_cnt_o};
   end
endmodule

// File: rtl/ttcan_ref_sync_chk.sv
module ttcan_ref_sync_chk #(
   parameter int TIME_W  = 16,
   parameter int CYC_W   = 6,
   parameter int GAP_BIT = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sof_i,
   input logic [TIME_W-1:0] local_time_i,
   input logic [TIME_W-1:0] cycle_time_i,
   input logic [TIME_W-1:0] mb30_trig_i,
   input logic              rx_ref_valid_i,
   input logic [7:0]        rx_data0_i,
   input logic              tx_ref_done_i,
   input logic [2:0]        mb31_cfg_i,
   input logic              irq_clr_i,
   input logic              slave_mode_o,
   input logic              master_mode_o,
   input logic [TIME_W-1:0] ref_mark_o,
   input logic [CYC_W-1:0]  cyc_cnt_o,
   input logic              gap_irq_o,
   input logic [TIME_W-1:0] hold_w
);
   // R2, R3: roles exclusive and both need the receive mailbox configured
   a_r3_roles_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(slave_mode_o && master_mode_o));
   a_r2_needs_mb31: assert property (@(posedge clk) disable iff (!rst_n)
      (slave_mode_o || master_mode_o) |-> (mb31_cfg_i == 3'b011));
   // R1
   a_r1_sof_capture: assert property (@(posedge clk) disable iff (!rst_n)
      sof_i |=> (hold_w == $past(local_time_i)));
   // R4, R6: accepted frame delivers the held value
   a_r4_mark_commit: assert property (@(posedge clk) disable iff (!rst_n)
      ((slave_mode_o && rx_ref_valid_i) || (master_mode_o && tx_ref_done_i))
      |=> (ref_mark_o == $past(hold_w)));
   // R10
   a_r10_mark_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !((slave_mode_o && rx_ref_valid_i) || (master_mode_o && tx_ref_done_i))
      |=> $stable(ref_mark_o));
   // R7
   a_r7_count_still: assert property (@(posedge clk) disable iff (!rst_n)
      (cycle_time_i != mb30_trig_i && !(slave_mode_o && rx_ref_valid_i))
      |=> $stable(cyc_cnt_o));
   // R5
   a_r5_gap_set: assert property (@(posedge clk) disable iff (!rst_n)
      (slave_mode_o && rx_ref_valid_i && rx_data0_i[GAP_BIT]) |=> gap_irq_o);
   a_r5_gap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (gap_irq_o && !irq_clr_i) |=> gap_irq_o);
endmodule

bind ttcan_ref_sync ttcan_ref_sync_chk #(
   .TIME_W(TIME_W), .CYC_W(CYC_W), .GAP_BIT(GAP_BIT)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .sof_i          (sof_i),
   .local_time_i   (local_time_i),
   .cycle_time_i   (cycle_time_i),
   .mb30_trig_i    (mb30_trig_i),
   .rx_ref_valid_i (rx_ref_valid_i),
   .rx_data0_i     (rx_data0_i),
   .tx_ref_done_i  (tx_ref_done_i),
   .mb31_cfg_i     (mb31_cfg_i),
   .irq_clr_i      (irq_clr_i),
   .slave_mode_o   (slave_mode_o),
   .master_mode_o  (master_mode_o),
   .ref_mark_o     (ref_mark_o),
   .cyc_cnt_o      (cyc_cnt_o),
   .gap_irq_o      (gap_irq_o),
   .hold_w         (sof_stamp_w)
);

// File: tb/tb_ttcan_ref_sync.sv
module tb_ttcan_ref_sync;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sof = 0, rxv = 0, txd = 0, clr = 0, pend = 0;
   logic [15:0] lt = '0, ct = '0, trig = 16'hFFFF;
   logic [7:0]  rxd = '0, txb = '0;
   logic [2:0]  cfg30 = 3'b001, cfg31 = 3'b011, cmax = 3'd1;
   logic [3:0]  dlc = 4'd0;
   logic        slave_o, master_o, irq_o;
   logic [15:0] mark_o;
   logic [5:0]  cyc_o;
   logic [7:0]  txo;

   typedef struct {
      logic [15:0] mark;
      logic [5:0]  cyc;
      logic        irq;
      string       tag;
   } exp_t;
   exp_t q[$];

   int checks = 0, fails = 0;
   bit done = 0;
   logic [15:0] m_hold = 0, m_mark = 0;
   logic [5:0]  m_cyc = 0;
   logic        m_irq = 0, m_pm = 0;

   always #10 clk = ~clk;

   ttcan_ref_sync dut (
      .clk(clk), .rst_n(rst_n), .sof_i(sof), .local_time_i(lt), .cycle_time_i(ct),
      .rx_ref_valid_i(rxv), .rx_data0_i(rxd), .tx_ref_done_i(txd), .tx_data0_i(txb),
      .mb30_tx_pend_i(pend), .mb30_cfg_i(cfg30), .mb30_dlc_i(dlc), .mb30_trig_i(trig),
      .mb31_cfg_i(cfg31), .cyc_max_i(cmax), .irq_clr_i(clr),
      .slave_mode_o(slave_o), .master_mode_o(master_o), .ref_mark_o(mark_o),
      .cyc_cnt_o(cyc_o), .tx_data0_o(txo), .gap_irq_o(irq_o)
   );

   task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic m_slave();
      return !pend && cfg30 != 3'b000 && cmax != 3'b111 && cfg31 == 3'b011;
   endfunction
   function automatic logic m_master();
      return pend && cfg30 == 3'b000 && dlc != 0 && cmax != 3'b111 && cfg31 == 3'b011;
   endfunction

   // driver: apply one cycle, push the model's expectation, clear pulses
   task automatic step(input string tag);
      exp_t e;
      logic [5:0] lim;
      logic sl, ms, match;
      sl = m_slave(); ms = m_master();
      match = (ct == trig);
      lim = (cmax >= 3'd5) ? 6'd63 : 6'((1 << (cmax + 1)) - 1);
      if ((sl && rxv) || (ms && txd)) m_mark = m_hold;
      if (sof) m_hold = lt;
      if (sl && rxv) m_cyc = rxd[5:0];
      else if (ms && match && !m_pm) m_cyc = (m_cyc >= lim) ? 6'd0 : m_cyc + 6'd1;
      m_pm = match;
      if (sl && rxv && rxd[7]) m_irq = 1'b1;
      else if (clr) m_irq = 1'b0;
      e.mark = m_mark; e.cyc = m_cyc; e.irq = m_irq; e.tag = tag;
      q.push_back(e);
      @(negedge clk);
      sof = 0; rxv = 0; txd = 0; clr = 0;
   endtask

   // monitor: compare registered outputs after each edge
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            cmp({e.tag, " mark"}, 32'(mark_o), 32'(e.mark));
            cmp({e.tag, " cyc"},  32'(cyc_o),  32'(e.cyc));
            cmp({e.tag, " irq"},  32'(irq_o),  32'(e.irq));
         end
      end
   end

   task automatic role_check(input string tag);
      #1;
      cmp({tag, " slave"},  32'(slave_o),  32'(m_slave()));
      cmp({tag, " master"}, 32'(master_o), 32'(m_master()));
   endtask

   initial begin
      #200000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      cmp("R9 reset mark", 32'(mark_o), 0);
      cmp("R9 reset cyc", 32'(cyc_o), 0);
      cmp("R9 reset irq", 32'(irq_o), 0);

      // role decoding R2 R3
      role_check("R2 slave cfg");
      cfg31 = 3'b010; role_check("R2 mb31 off");
      cfg31 = 3'b011; cmax = 3'b111; role_check("R2 cmax barred");
      cmax = 3'd1; cfg30 = 3'b000; role_check("R2 mb30 zero");
      pend = 1; role_check("R3 dlc zero");
      dlc = 4'd8; role_check("R3 master cfg");
      cmax = 3'b111; role_check("R3 cmax barred");
      cmax = 3'd1; cfg30 = 3'b001; role_check("R3 mb30 nonzero");

      // slave role
      pend = 0; cfg30 = 3'b001; dlc = 0;
      step("R9 idle");
      lt = 16'h1234; sof = 1; step("R1 sof");
      lt = 16'h1300; step("R10 idle");
      rxd = 8'h85; rxv = 1; step("R4 rx gap");
      step("R5 sticky");
      lt = 16'h2222; sof = 1; step("R10 sof no frame");
      step("R10 keep");
      clr = 1; step("R5 clear");
      rxd = 8'h2A; rxv = 1; step("R4 rx nogap");
      step("R4 after");
      rxd = 8'h81; rxv = 1; clr = 1; step("R5 set wins");
      txd = 1; lt = 16'h3333; sof = 1; step("R6 tx ignored in slave");
      ct = 16'h0050; trig = 16'h0050; step("R7 no advance in slave");
      step("R7 hold");

      // master role
      ct = 0; pend = 1; cfg30 = 3'b000; dlc = 4'd8; cmax = 3'd1;
      role_check("R3 master again");
      txb = 8'hC0; #1;
      cmp("R8 byte", 32'(txo), 32'({2'b11, cyc_o}));
      step("R7 idle");
      txd = 1; step("R6 tx commit");
      rxd = 8'h03; rxv = 1; lt = 16'h4444; sof = 1; step("R4 rx ignored in master");
      for (int k = 0; k < 6; k++) begin
         ct = trig; step("R7 match");
         step("R7 long match");
         ct = 16'h0001; step("R7 miss");
      end
      txb = 8'h40; #1;
      cmp("R8 byte", 32'(txo), 32'({2'b01, cyc_o}));
      cmax = 3'd2;
      for (int k = 0; k < 9; k++) begin
         ct = trig; step("R7 cmax2");
         ct = 16'h0002; step("R7 cmax2 miss");
      end
      cmax = 3'd6;
      for (int k = 0; k < 66; k++) begin
         ct = trig; step("R7 cap 63");
         ct = 16'h0003; step("R7 cap miss");
      end
      txb = 8'h80; #1;
      cmp("R8 byte", 32'(txo), 32'({2'b10, cyc_o}));
      txd = 1; step("R6 tx second");
      step("R6 after");
      repeat (3) @(negedge clk);
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule